// File: doc/BRIEF.md
# Cyclic Position Telegram Serializer with CRC

This block assembles the byte stream of one cyclic position readout. A start pulse takes a snapshot of the sensor words: status, singleturn position, multiturn count, life counter, error flags and temperature. From then on, each read strobe moves the output to the next byte of the telegram. The telegram ends with a 16-bit checksum, which is built up byte by byte as the data bytes are read. Once the telegram is complete, every further read gives zero until the next start pulse.

A format bit is sampled at the start pulse and selects one of two layouts:

- **Short layout (12 bytes):** carries 24 singleturn bits and 16 multiturn bits.
- **Full layout (14 bytes):** adds a singleturn extension byte and the top multiturn byte, for 26 singleturn bits and 24 multiturn bits.

The byte on `dout` is always the byte that the next read strobe will consume. The serial link and any register addressing sit outside this block.

Top module: `pos_telegram_ser`

## Requirements
- R1: While `rst_n` is low and after reset until the first start pulse, `dout` is 0x00 and `last_byte` is 0.
- R2: A start pulse latches all input words. The cycle after it, `dout` shows the latched status byte. Changes on the input words after the start pulse do not alter the telegram being read.
- R3: With the format bit 0 at the start pulse, the bytes in order are:
  1. status
  2. ST[9:2]
  3. ST[17:10]
  4. ST[25:18]
  5. MT[7:0]
  6. MT[15:8]
  7. life
  8. error
  9. TEMP[7:0]
  10. TEMP[15:8]
  11. CRC[7:0]
  12. CRC[15:8]
- R4: With the format bit 1 at the start pulse, the bytes in order are:
  1. status
  2. the extension byte `{ST[1:0], 6'b0}`
  3. ST[9:2]
  4. ST[17:10]
  5. ST[25:18]
  6. MT[7:0]
  7. MT[15:8]
  8. MT[23:16]
  9. life
  10. error
  11. TEMP[7:0]
  12. TEMP[15:8]
  13. CRC[7:0]
  14. CRC[15:8]
- R5: The CRC covers every data byte of the telegram, starting with status. Its parameters are:
  - generator polynomial 0x4EAB (x^16 term implied);
  - preset value 0xFFFF;
  - bits fed most-significant first;
  - no final XOR.
  
  The low CRC byte is sent before the high CRC byte.
- R6: The CRC is preset again at every start pulse. Two telegrams of identical data therefore carry identical CRCs.
- R7: `last_byte` is 1 exactly while the CRC high byte is on `dout`.
- R8: Reads past the CRC high byte return 0x00, with `last_byte` 0, until the next start pulse.
- R9: A start pulse restarts the telegram at any point, including in the middle of a readout. A change of the format bit after the start pulse has no effect on the telegram in progress.
- R10: In a cycle with neither a start pulse nor a read strobe, `dout` and `last_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Start of a cyclic readout; latches inputs and format |
| rd_strobe | input | 1 | Consumes the current byte and advances to the next |
| full_fmt | input | 1 | Layout select: 0 short, 1 full |
| in_status | input | 8 | Status byte |
| in_st | input | 26 | Singleturn position |
| in_mt | input | 24 | Multiturn count |
| in_life | input | 8 | Life counter |
| in_err | input | 8 | Error flags |
| in_temp | input | 16 | Temperature |
| dout | output | 8 | Current telegram byte |
| last_byte | output | 1 | High while the CRC high byte is presented |

## Verification
The hardest situation to reach from the ports is a start pulse in the middle of a readout. At that point the CRC register holds a partial sum, and the format bit may be about to change. The stimulus reaches it in two ways:
- it cuts one full telegram short at its fourth byte and restarts in the short format, with different data;
- it toggles the format bit and the input words right after a start.

A reference model that rebuilds each telegram from queued bytes then shows whether any stale CRC state or stale layout leaks into the new telegram. Read strobes are interleaved with idle cycles and run several bytes past the end of the frame, which covers R8 and R10.

// File: rtl/pos_telegram_ser.sv
module pos_telegram_ser #(
  parameter logic [15:0] CRC_POLY = 16'h4EAB,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_start,
  input  logic        rd_strobe,
  input  logic        full_fmt,
  input  logic [7:0]  in_status,
  input  logic [25:0] in_st,
  input  logic [23:0] in_mt,
  input  logic [7:0]  in_life,
  input  logic [7:0]  in_err,
  input  logic [15:0] in_temp,
  output logic [7:0]  dout,
  output logic        last_byte
);

  localparam logic [3:0] IDLE_POS = 4'hF;

  logic        fmt_q;
  logic [3:0]  pos;
  logic [15:0] crc;
  logic [7:0]  stat_q, life_q, err_q;
  logic [25:0] st_q;
  logic [23:0] mt_q;
  logic [15:0] temp_q;

  logic [3:0]  flen, slot;
  logic [7:0]  data_byte;
  logic        in_data, at_crc_lo, at_crc_hi;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  assign flen      = fmt_q ? 4'd14 : 4'd12;
  assign in_data   = pos < flen - 4'd2;
  assign at_crc_lo = pos == flen - 4'd2;
  assign at_crc_hi = pos == flen - 4'd1;
  assign slot      = fmt_q ? pos : pos + {3'd0, pos >= 4'd1} + {3'd0, pos >= 4'd6};

  always_comb begin
    case (slot)
      4'd0:    data_byte = stat_q;
      4'd1:    data_byte = {st_q[1:0], 6'd0};
      4'd2:    data_byte = st_q[9:2];
      4'd3:    data_byte = st_q[17:10];
      4'd4:    data_byte = st_q[25:18];
      4'd5:    data_byte = mt_q[7:0];
      4'd6:    data_byte = mt_q[15:8];
      4'd7:    data_byte = mt_q[23:16];
      4'd8:    data_byte = life_q;
      4'd9:    data_byte = err_q;
      4'd10:   data_byte = temp_q[7:0];
      4'd11:   data_byte = temp_q[15:8];
      default: data_byte = 8'd0;
    endcase
  end

  assign dout = in_data   ? data_byte :
                at_crc_lo ? crc[7:0]  :
                at_crc_hi ? crc[15:8] : 8'd0;
  assign last_byte = at_crc_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q  <= 1'b0;
      pos    <= IDLE_POS;
      crc    <= CRC_INIT;
      stat_q <= '0;
      st_q   <= '0;
      mt_q   <= '0;
      life_q <= '0;
      err_q  <= '0;
      temp_q <= '0;
    end else if (cyc_start) begin
      fmt_q  <= full_fmt;
      pos    <= 4'd0;
      crc    <= CRC_INIT;
      stat_q <= in_status;
      st_q   <= in_st;
      mt_q   <= in_mt;
      life_q <= in_life;
      err_q  <= in_err;
      temp_q <= in_temp;
    end else if (rd_strobe && pos < flen) begin
      pos <= pos + 4'd1;
      if (in_data) crc <= crc_step(crc, data_byte);
    end
  end

endmodule

// File: rtl/pos_telegram_chk.sv
module pos_telegram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_start,
  input logic       rd_strobe,
  input logic [7:0] in_status,
  input logic [7:0] dout,
  input logic       last_byte
);

  // R2
  status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (dout == $past(in_status)));

  // R7
  no_last_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !last_byte);

  // R8
  zero_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && rd_strobe && !cyc_start) |=> (dout == 8'd0 && !last_byte));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && !rd_strobe) |=> ($stable(dout) && $stable(last_byte)));

  // R1
  always @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (last_byte == 1'b0 || $isunknown(last_byte));

endmodule

bind pos_telegram_ser pos_telegram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .rd_strobe(rd_strobe),
  .in_status(in_status), .dout(dout), .last_byte(last_byte)
);

// File: tb/sim_pos_telegram_ser.sv
`timescale 1ns/1ps
module sim_pos_telegram_ser;
  logic clk = 1'b0;
  logic rst_n = 1'b0, cyc_start = 1'b0, rd_strobe = 1'b0, full_fmt = 1'b0;
  logic [7:0]  in_status = '0, in_life = '0, in_err = '0;
  logic [25:0] in_st = '0;
  logic [23:0] in_mt = '0;
  logic [15:0] in_temp = '0;
  logic [7:0]  dout;
  logic        last_byte;

  int checks = 0, errors = 0;
  string phase = "R1";
  byte unsigned frame_q[$];
  int idx = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pos_telegram_ser u0 (.*);

  function automatic logic [15:0] ref_crc(input byte unsigned q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k])
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ q[k][b];
        c = c << 1;
        if (fb) c = c ^ 16'h4EAB;
      end
    return c;
  endfunction

  task automatic build_frame();
    logic [15:0] c;
    frame_q.delete();
    frame_q.push_back(in_status);
    if (full_fmt) frame_q.push_back({in_st[1:0], 6'd0});
    frame_q.push_back(in_st[9:2]);
    frame_q.push_back(in_st[17:10]);
    frame_q.push_back(in_st[25:18]);
    frame_q.push_back(in_mt[7:0]);
    frame_q.push_back(in_mt[15:8]);
    if (full_fmt) frame_q.push_back(in_mt[23:16]);
    frame_q.push_back(in_life);
    frame_q.push_back(in_err);
    frame_q.push_back(in_temp[7:0]);
    frame_q.push_back(in_temp[15:8]);
    c = ref_crc(frame_q);
    frame_q.push_back(c[7:0]);
    frame_q.push_back(c[15:8]);
    idx = 0;
  endtask

  task automatic compare();
    logic [7:0] ed;
    logic el;
    ed = (idx < frame_q.size()) ? frame_q[idx] : 8'd0;
    el = (frame_q.size() != 0) && (idx == frame_q.size() - 1);
    checks++;
    if (dout !== ed) begin
      errors++;
      $display("FAIL %s dout byte %0d: got %02h expected %02h", phase, idx, dout, ed);
    end
    checks++;
    if (last_byte !== el) begin
      errors++;
      $display("FAIL %s/R7 last_byte at byte %0d: got %b expected %b", phase, idx, last_byte, el);
    end
  endtask

  task automatic cyc(input bit s, input bit r);
    cyc_start = s;
    rd_strobe = r;
    @(posedge clk);
    if (!rst_n) begin
      frame_q.delete();
      idx = 0;
    end else if (s) build_frame();
    else if (r && idx < frame_q.size()) idx++;
    @(negedge clk);
    cyc_start = 1'b0;
    rd_strobe = 1'b0;
    compare();
  endtask

  task automatic load(input logic [7:0] s, input logic [25:0] st, input logic [23:0] mt,
                      input logic [7:0] l, input logic [7:0] e, input logic [15:0] t);
    in_status = s; in_st = st; in_mt = mt; in_life = l; in_err = e; in_temp = t;
  endtask

  initial begin
    @(negedge clk);
    phase = "R1";
    repeat (3) cyc(0, 1);
    rst_n = 1'b1;
    cyc(0, 1);
    cyc(0, 0);

    phase = "R3_R5";
    full_fmt = 0;
    load(8'hA5, 26'h2ABCDEF, 24'h123456, 8'h77, 8'h0F, 16'hBEEF);
    cyc(1, 0);
    for (int i = 0; i < 14; i++) begin
      phase = (i >= 11) ? "R8" : "R3_R5";
      cyc(0, 1);
      if (i % 3 == 0) begin phase = "R10"; cyc(0, 0); end
    end

    phase = "R4_R2";
    full_fmt = 1;
    load(8'h3C, 26'h3FFFFFF, 24'hFEDCBA, 8'h01, 8'h80, 16'h0102);
    cyc(1, 0);
    full_fmt = 0;
    load(8'h00, 26'h0, 24'h0, 8'h00, 8'h00, 16'h0);
    for (int i = 0; i < 16; i++) cyc(0, 1);

    phase = "R6";
    full_fmt = 1;
    load(8'h3C, 26'h3FFFFFF, 24'hFEDCBA, 8'h01, 8'h80, 16'h0102);
    cyc(1, 0);
    for (int i = 0; i < 15; i++) cyc(0, 1);

    phase = "R9";
    load(8'h11, 26'h1234567, 24'hABCDEF, 8'h22, 8'h33, 16'h4455);
    cyc(1, 0);
    repeat (4) cyc(0, 1);
    full_fmt = 0;
    load(8'h99, 26'h0F0F0F0, 24'h0F0F0F, 8'h88, 8'h77, 16'h6655);
    cyc(1, 1);
    full_fmt = 1;
    for (int i = 0; i < 13; i++) cyc(0, 1);

    phase = "R3_R4_R5";
    for (int n = 0; n < 40; n++) begin
      full_fmt = $urandom_range(0, 1);
      load($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      cyc(1, 0);
      for (int i = 0; i < 16; i++) cyc(0, $urandom_range(0, 3) != 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule